// File: doc/BRIEF.md
# I2C Bus Busy Monitor

This block sits beside a local I2C master on a bus that other masters share. It watches the synchronized SCL and SDA samples and tells the local master whether it may begin a transfer. A START condition marks the bus busy at once. A STOP condition starts a bus-free gap, and the bus is released only when that gap has run out. The gap defaults to 4.7 us and is converted to system clock cycles, rounding up.

After reset the block cannot know whether a transfer is already under way, because it may have missed a START. When the shared pins are in I2C management mode, it therefore starts out busy. It leaves that state in one of two ways: through a STOP followed by the bus-free gap, or when both lines have stayed high without a break for an idle period (4 ms by default). When the pins are in another mode, this check is skipped and the bus starts out free.

The monitor also emits one-cycle START and STOP pulses for the master's sequencer.

Top module: `i2c_busy_monitor`

## Requirements
- R1: A START (SDA sampled high in one cycle and low in the next, with SCL high in both samples) sets bus_busy_o and pulses start_seen_o for one cycle. Both outputs change on the clock edge that samples the low SDA.
- R2: A STOP (SDA sampled low then high, with SCL high in both samples) pulses stop_seen_o on the edge that samples the high SDA. bus_busy_o stays high on that edge and is cleared on the FREE-th following edge. FREE = ceil(CLK_HZ * BUS_FREE_NS / 1e9), and BUS_FREE_NS defaults to 4700.
- R3: An SDA change while SCL is low, or an SCL change of any kind, produces no pulse and does not change bus_busy_o.
- R4: A reset taken with i2c_mode_i = 1 leaves bus_busy_o = 1, and both pulse outputs 0, in the cycles that follow.
- R5: In that post-reset state, bus_busy_o clears on the IDLE-th consecutive edge at which SCL and SDA are both sampled high. IDLE = ceil(CLK_HZ * IDLE_US / 1e6), and IDLE_US defaults to 4000.
- R6: Any edge at which SCL or SDA is sampled low during the idle count sets that count back to zero.
- R7: A STOP seen in the post-reset state starts the R2 bus-free gap, and the bus is released when that gap ends.
- R8: A reset taken with i2c_mode_i = 0 leaves bus_busy_o = 0. i2c_mode_i is looked at only during reset, so changing it afterwards has no effect on bus_busy_o.
- R9: A START during the bus-free gap cancels the gap. bus_busy_o stays high until a later STOP and a full gap.
- R10: A second STOP during the bus-free gap restarts the gap from that STOP.
- R11: The line levels held during reset are treated as the previous sample, so no START or STOP is reported on the first edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL sample |
| sda_i | input | 1 | Synchronized SDA sample |
| i2c_mode_i | input | 1 | 1 when the shared pins are in I2C management mode; sampled during reset |
| bus_busy_o | output | 1 | 1 while the local master must not start a transfer |
| start_seen_o | output | 1 | One-cycle pulse on a detected START |
| stop_seen_o | output | 1 | One-cycle pulse on a detected STOP |

## Verification
Three kinds of internal fault show up at the ports, each at a point that can be predicted to the cycle. A wrong state register shows on bus_busy_o on the edge after the event that should have moved it. An off-by-one in the gap counter or the idle counter moves the busy-to-free edge exactly FREE or IDLE cycles after the triggering STOP or the last low line level. The bench samples bus_busy_o on the cycle just before that edge and on the edge itself. A stale previous-sample register shows as a false or missing pulse on the first edge after reset or after a line change.

// File: rtl/ibm_pkg.sv
package ibm_pkg;

    typedef enum logic [1:0] {
        BUS_UNKNOWN = 2'd0,
        BUS_BUSY    = 2'd1,
        BUS_HOLDOFF = 2'd2,
        BUS_FREE    = 2'd3
    } bus_state_e;

    typedef struct packed {
        logic start;
        logic stop;
    } line_evt_t;

    // Cycles covering a duration, rounded up; never below one.
    function automatic int unsigned span_cycles(longint unsigned hz,
                                                longint unsigned amount,
                                                longint unsigned units_per_sec);
        longint unsigned c;
        c = (hz * amount + units_per_sec - 1) / units_per_sec;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/ibm_line_events.sv
module ibm_line_events
    import ibm_pkg::*;
(
    input  logic      clk,
    input  logic      scl_i,
    input  logic      sda_i,
    output line_evt_t evt
);
    logic scl_q;
    logic sda_q;

    // Previous samples follow the lines during reset as well.
    always_ff @(posedge clk) begin
        scl_q <= scl_i;
        sda_q <= sda_i;
    end

    always_comb begin
        evt.start = scl_q & scl_i & sda_q & ~sda_i;
        evt.stop  = scl_q & scl_i & ~sda_q & sda_i;
    end
endmodule

// File: rtl/ibm_hold_timer.sv
module ibm_hold_timer #(
    parameter int unsigned LIMIT = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clear,
    output logic done
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear || !run) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);  // R5
endmodule

// File: rtl/ibm_state_ctrl.sv
module ibm_state_ctrl
    import ibm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      i2c_mode,
    input  line_evt_t evt,
    input  logic      free_done,
    input  logic      idle_done,
    output logic      in_holdoff,
    output logic      in_unknown,
    output logic      bus_busy
);
    bus_state_e state;
    bus_state_e nxt;

    always_comb begin
        nxt = state;
        if (evt.stop) begin
            nxt = BUS_HOLDOFF;
        end else if (evt.start) begin
            nxt = BUS_BUSY;
        end else begin
            case (state)
                BUS_UNKNOWN: if (idle_done) nxt = BUS_FREE;
                BUS_HOLDOFF: if (free_done) nxt = BUS_FREE;
                default:     nxt = state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= i2c_mode ? BUS_UNKNOWN : BUS_FREE;
        end else begin
            state <= nxt;
        end
    end

    assign in_holdoff = (state == BUS_HOLDOFF);
    assign in_unknown = (state == BUS_UNKNOWN);
    assign bus_busy   = (state != BUS_FREE);

    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> bus_busy);  // R1
    AST_STOP_HOLDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> bus_busy);  // R2
    AST_RELEASE_NEEDS_TIMER: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_busy) |-> ($past(free_done) || $past(idle_done)));  // R2
    AST_MODE_ON_BUSY: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && $past(i2c_mode)) |-> bus_busy);  // R4
    AST_MODE_OFF_FREE: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !$past(i2c_mode)) |-> !bus_busy);  // R8
endmodule

// File: rtl/i2c_busy_monitor.sv
module i2c_busy_monitor
    import ibm_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned BUS_FREE_NS = 4700,
    parameter int unsigned IDLE_US     = 4000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic i2c_mode_i,
    output logic bus_busy_o,
    output logic start_seen_o,
    output logic stop_seen_o
);
    localparam int unsigned FREE_CYC = span_cycles(CLK_HZ, BUS_FREE_NS, 64'd1_000_000_000);
    localparam int unsigned IDLE_CYC = span_cycles(CLK_HZ, IDLE_US, 64'd1_000_000);

    line_evt_t evt;
    logic      free_done;
    logic      idle_done;
    logic      in_holdoff;
    logic      in_unknown;
    logic      lines_high;

    assign lines_high = scl_i & sda_i;

    ibm_line_events u_events (
        .clk   (clk),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    // Bus-free gap: restarted by every STOP.
    ibm_hold_timer #(.LIMIT(FREE_CYC)) u_free_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (in_holdoff),
        .clear (evt.stop),
        .done  (free_done)
    );

    // Post-reset idle watch: any low level zeroes the count.
    ibm_hold_timer #(.LIMIT(IDLE_CYC)) u_idle_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (in_unknown & lines_high),
        .clear (1'b0),
        .done  (idle_done)
    );

    ibm_state_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .i2c_mode   (i2c_mode_i),
        .evt        (evt),
        .free_done  (free_done),
        .idle_done  (idle_done),
        .in_holdoff (in_holdoff),
        .in_unknown (in_unknown),
        .bus_busy   (bus_busy_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            start_seen_o <= 1'b0;
            stop_seen_o  <= 1'b0;
        end else begin
            start_seen_o <= evt.start;
            stop_seen_o  <= evt.stop;
        end
    end

    AST_START_PULSE_BUSY: assert property (@(posedge clk) disable iff (rst)
        start_seen_o |-> bus_busy_o);  // R1
    AST_STOP_PULSE_BUSY: assert property (@(posedge clk) disable iff (rst)
        stop_seen_o |-> bus_busy_o);  // R2
endmodule

// File: tb/tb_i2c_busy_monitor.sv
module tb_i2c_busy_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int unsigned TB_HZ = 2_000_000;
    localparam longint unsigned FREE_L = (longint'(TB_HZ) * 4700 + 999_999_999) / 1_000_000_000;
    localparam longint unsigned IDLE_L = (longint'(TB_HZ) * 4000 + 999_999) / 1_000_000;
    localparam int FREE_EXP = int'(FREE_L);
    localparam int IDLE_EXP = int'(IDLE_L);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic mode = 1'b0;
    logic busy, st, sp;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_busy_monitor #(.CLK_HZ(TB_HZ), .BUS_FREE_NS(4700), .IDLE_US(4000)) dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .i2c_mode_i(mode),
        .bus_busy_o(busy), .start_seen_o(st), .stop_seen_o(sp)
    );

    // Row layout {scl, sda, busy, start_seen, stop_seen}, from a free bus.
    localparam int NV = 21;
    localparam logic [4:0] VEC [NV] = '{
        5'b11_000, 5'b10_110, 5'b00_100, 5'b01_100, 5'b11_100,
        5'b01_100, 5'b00_100, 5'b10_100, 5'b11_101, 5'b11_100,
        5'b11_100, 5'b11_100, 5'b11_100, 5'b11_100, 5'b11_100,
        5'b11_100, 5'b11_100, 5'b11_100, 5'b11_000, 5'b10_110,
        5'b11_101
    };

    task automatic check3(string req, logic eb, logic es, logic ep);
        checks++;
        if (busy !== eb || st !== es || sp !== ep) begin
            errors++;
            $display("FAIL %s: busy/start/stop actual %b%b%b expected %b%b%b",
                     req, busy, st, sp, eb, es, ep);
        end
    endtask

    task automatic drive(logic s, logic d);
        scl = s;
        sda = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(logic m, logic s, logic d);
        @(negedge clk);
        rst = 1'b1;
        mode = m;
        scl = s;
        sda = d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R4: reset state in management mode
        do_reset(1'b1, 1'b1, 1'b1);
        check3("R4 reset busy in i2c mode", 1'b1, 1'b0, 1'b0);

        // R8: reset state outside management mode
        do_reset(1'b0, 1'b1, 1'b1);
        check3("R8 reset free outside i2c mode", 1'b0, 1'b0, 1'b0);

        // R1 R2 R3: vector walk
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][4], VEC[i][3]);
            check3($sformatf("R1/R2/R3 vector %0d", i), VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R8: mode change after reset ignored
        do_reset(1'b0, 1'b1, 1'b1);
        mode = 1'b1;
        repeat (5) drive(1'b1, 1'b1);
        check3("R8 late mode change ignored", 1'b0, 1'b0, 1'b0);

        // R5: idle release exactly IDLE_EXP edges
        do_reset(1'b1, 1'b1, 1'b1);
        repeat (IDLE_EXP - 1) drive(1'b1, 1'b1);
        check3("R5 still busy before idle end", 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b1);
        check3("R5 free at idle end", 1'b0, 1'b0, 1'b0);

        // R6: a low SCL restarts the idle count
        do_reset(1'b1, 1'b1, 1'b1);
        repeat (IDLE_EXP / 2) drive(1'b1, 1'b1);
        drive(1'b0, 1'b1);
        check3("R6 SCL low no event", 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b1);
        repeat (IDLE_EXP - 2) drive(1'b1, 1'b1);
        check3("R6 busy one edge before restarted end", 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b1);
        check3("R6 free at restarted end", 1'b0, 1'b0, 1'b0);

        // R7: STOP in post-reset state
        do_reset(1'b1, 1'b1, 1'b1);
        drive(1'b0, 1'b1);
        drive(1'b0, 1'b0);
        drive(1'b1, 1'b0);
        check3("R3 SCL rise with SDA low no event", 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b1);
        check3("R7 stop after reset", 1'b1, 1'b0, 1'b1);
        repeat (FREE_EXP - 1) drive(1'b1, 1'b1);
        check3("R7 busy until gap end", 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b1);
        check3("R7 free after gap", 1'b0, 1'b0, 1'b0);

        // R9: START during the gap cancels it
        do_reset(1'b0, 1'b1, 1'b1);
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b1);
        repeat (5) drive(1'b1, 1'b1);
        drive(1'b1, 1'b0);
        check3("R9 start in gap", 1'b1, 1'b1, 1'b0);
        repeat (FREE_EXP + 5) drive(1'b1, 1'b0);
        check3("R9 gap cancelled stays busy", 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b1);
        check3("R9 new stop", 1'b1, 1'b0, 1'b1);
        repeat (FREE_EXP) drive(1'b1, 1'b1);
        check3("R9 free after new gap", 1'b0, 1'b0, 1'b0);

        // R10: second STOP restarts the gap
        do_reset(1'b0, 1'b1, 1'b1);
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b1);
        repeat (5) drive(1'b1, 1'b1);
        drive(1'b0, 1'b1);
        drive(1'b0, 1'b0);
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b1);
        check3("R10 second stop", 1'b1, 1'b0, 1'b1);
        repeat (FREE_EXP - 1) drive(1'b1, 1'b1);
        check3("R10 busy until restarted gap end", 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b1);
        check3("R10 free after restarted gap", 1'b0, 1'b0, 1'b0);

        // R11: levels held in reset give no event on first edge
        do_reset(1'b0, 1'b1, 1'b0);
        drive(1'b1, 1'b0);
        check3("R11 no start after reset with SDA low", 1'b0, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule